// File: doc/BRIEF.md
# Serial-Bus Clock-Enable Control Target

This block is a target on a two-wire serial bus. It sits in front of a bank of six differential clock output pairs and holds the enable mask for them. A fast system clock oversamples the open-drain SCL and SDA lines. The block recognises start and stop conditions and matches its own device address. It acknowledges the bytes it accepts and drives SDA low only when it acknowledges a byte or sends a read bit.

There is no register addressing. Every transaction begins at register 0 and moves up one register per byte.

In a write, the host sends two bytes after the address: a command byte and then a count byte. The block acknowledges both and discards their contents. The data bytes that follow fill the registers in turn.

In a read, the block returns a count byte first and then the six registers in order.

Two of the registers carry the per-pair enable bits. The true and complement enables of each pair are driven as separate, registered outputs.

Top module: `clkctl_target`

## Requirements
- R1: The block acknowledges the address byte 0xD2 (write) and 0xD3 (read). It leaves any other address byte unacknowledged and ignores the rest of that transaction, so register contents and enables do not change.
- R2: In a write, the block acknowledges the first two bytes after the address and discards their contents. Later data bytes load register 0, then 1, 2 and so on.
- R3: A write that ends with a stop after any complete data byte leaves the registers it did not reach unchanged.
- R4: A read returns the count value 6 first, then registers 0 to 5 in ascending order. The target sends each byte MSB first, and the host acknowledges each one.
- R5: The pair enables are mapped as follows, with 1 meaning enabled:
  - pair 0: register 0 bit 7
  - pair 1: register 0 bit 6
  - pair 2: register 1 bit 3
  - pair 3: register 1 bit 6
  - pair 4: register 1 bit 0
  - pair 5: register 1 bit 2
- R6: After reset, every enable output is 1. The registers read back as 0xC0, 0x4D, 0x00, 0x00, 0x00 and 0x06, and SDA is released.
- R7: The block acknowledges data bytes aimed at register 5 or beyond, but they change no register.
- R8: A repeated start returns the byte pointer to register 0, for writes and for reads.
- R9: For each pair, the true and complement enables always carry the same value. A disabled pair drives both low.
- R10: The enables change only as the result of a data byte written to register 0 or 1. The change appears within a few system clocks after the SCL falling edge that ends that byte's eighth bit, that is, before the acknowledge clock goes high.
- R11: The block begins pulling SDA low only while SCL is low. It releases SDA on a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| pair_en_t_o | output | 6 | True-side enable for each output pair |
| pair_en_c_o | output | 6 | Complement-side enable for each output pair |

## Verification
The checks assume that the host changes SDA only while SCL is low, except when it forms a start or a stop. They also assume that every SCL high and low phase lasts well longer than the three-clock synchronizer delay. Finally, they assume the host never begins a start while the target is shifting out read data. The stimulus meets all three conditions: it holds every bus phase for 20 system clocks, places SDA changes a quarter bit after each SCL fall, and issues repeated starts only after a write acknowledge or a read that ended with a not-acknowledge.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DW    = 8;
  localparam int NREG  = 6;
  localparam int NPAIR = 6;
  localparam int IW    = $clog2(NREG);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK} bus_st_t;

  // power-on contents of each register
  function automatic logic [DW-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'hC0;
      1:       return 8'h4D;
      5:       return 8'h06;
      default: return '0;
    endcase
  endfunction

  // which register carries the enable of pair p
  function automatic int pair_reg(input int p);
    return (p < 2) ? 0 : 1;
  endfunction

  // which bit of that register carries the enable of pair p
  function automatic int pair_bit(input int p);
    case (p)
      0:       return 7;
      1:       return 6;
      2:       return 3;
      3:       return 6;
      4:       return 0;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/clkctl_bus_sync.sv
module clkctl_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/clkctl_bus_engine.sv
module clkctl_bus_engine
  import clkctl_pkg::*;
#(
  parameter logic [6:0]    DEV_ADDR   = 7'h69,
  parameter int            NWR        = 5,
  parameter logic [DW-1:0] BYTE_COUNT = 8'd6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic [IW-1:0] rd_idx
);
  localparam int BW = $clog2(DW + 1);
  localparam int PW = $clog2(NREG + NWR + 4);

  bus_st_t       st;
  logic [DW-1:0] sr, sh, tx_byte;
  logic [BW-1:0] bitcnt;
  logic [PW-1:0] pos;
  logic          in_addr, is_read;

  // byte presented in a read: count first, then registers, then all-ones
  assign rd_idx = IW'(pos - PW'(1));
  always_comb begin
    if (pos == '0)                tx_byte = BYTE_COUNT;
    else if (pos <= PW'(NREG))    tx_byte = rd_data;
    else                          tx_byte = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      sr      <= '0;
      sh      <= '0;
      bitcnt  <= '0;
      pos     <= '0;
      in_addr <= 1'b0;
      is_read <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        st      <= ST_RX;
        in_addr <= 1'b1;
        bitcnt  <= '0;
        pos     <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt < BW'(DW)) begin
              sr     <= {sr[DW-2:0], sda_s};
              bitcnt <= bitcnt + BW'(1);
            end else if (scl_fall && bitcnt == BW'(DW)) begin
              bitcnt <= '0;
              if (in_addr) begin
                if (sr[DW-1:1] == DEV_ADDR) begin
                  is_read <= sr[0];
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                if (pos >= PW'(2) && pos < PW'(NWR + 2)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IW'(pos - PW'(2));
                  wr_data <= sr;
                end
                if (pos != '1) pos <= pos + PW'(1);
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              in_addr <= 1'b0;
              bitcnt  <= '0;
              if (is_read) begin
                st     <= ST_TX;
                sh     <= tx_byte;
                sda_oe <= ~tx_byte[DW-1];
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == BW'(DW - 1)) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
                if (pos != '1) pos <= pos + PW'(1);
              end else begin
                sh     <= {sh[DW-2:0], 1'b0};
                sda_oe <= ~sh[DW-2];
                bitcnt <= bitcnt + BW'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IDLE;
            end else if (scl_fall) begin
              st     <= ST_TX;
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[DW-1];
              bitcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkctl_reg_bank.sv
module clkctl_reg_bank
  import clkctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic [IW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] regs_o
);
  logic [NREG-1:0][DW-1:0] mem;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                              mem[i] <= reg_default(i);
      else if (wr_en && wr_idx == IW'(i))   mem[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IW'(i)) rd_data = mem[i];
  end

  assign regs_o = mem;
endmodule

// File: rtl/clkctl_pair_gate.sv
module clkctl_pair_gate
  import clkctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NREG*DW-1:0] regs,
  output logic [NPAIR-1:0]   en_t,
  output logic [NPAIR-1:0]   en_c
);
  logic [NPAIR-1:0] sel;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int SRC = pair_reg(p) * DW + pair_bit(p);
    assign sel[p] = regs[SRC];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_t <= '1;
      en_c <= '1;
    end else begin
      en_t <= sel;
      en_c <= sel;
    end
  end
endmodule

// File: rtl/clkctl_target.sv
module clkctl_target
  import clkctl_pkg::*;
#(
  parameter logic [6:0]    DEV_ADDR    = 7'h69,
  parameter int            NWR         = 5,
  parameter logic [DW-1:0] BYTE_COUNT  = 8'd6,
  parameter int            SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [NPAIR-1:0] pair_en_t_o,
  output logic [NPAIR-1:0] pair_en_c_o
);
  logic               sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic               wr_en;
  logic [IW-1:0]      wr_idx, rd_idx;
  logic [DW-1:0]      wr_data, rd_data;
  logic [NREG*DW-1:0] regs;

  clkctl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  clkctl_bus_engine #(.DEV_ADDR(DEV_ADDR), .NWR(NWR), .BYTE_COUNT(BYTE_COUNT)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data),
    .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx)
  );

  clkctl_reg_bank u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs)
  );

  clkctl_pair_gate u_gate (
    .clk(clk), .rst(rst), .regs(regs), .en_t(pair_en_t_o), .en_c(pair_en_c_o)
  );
endmodule

// File: rtl/clkctl_target_chk.sv
module clkctl_target_chk
  import clkctl_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             stop_evt,
  input logic             sda_oe,
  input logic             wr_en,
  input logic [NPAIR-1:0] en_t,
  input logic [NPAIR-1:0] en_c
);
  AST_RESET_ENABLES: assert property (@(posedge clk) rst |=> (en_t == '1 && en_c == '1)); // R6
  AST_PAIR_TC_MATCH: assert property (@(posedge clk) disable iff (rst) en_t == en_c); // R9
  AST_EN_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) !$past(wr_en, 2) |-> $stable(en_t)); // R10
  AST_SDA_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_i); // R11
  AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (rst) stop_evt |=> !sda_oe); // R11
endmodule

bind clkctl_target clkctl_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .stop_evt(stop_evt), .sda_oe(sda_oe_o),
  .wr_en(wr_en), .en_t(pair_en_t_o), .en_c(pair_en_c_o)
);

// File: tb/tb_clkctl_target.sv
module tb_clkctl_target;
  import clkctl_pkg::*;
  localparam int Q = 20;

  logic clk = 1'b0, rst = 1'b1, scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe, sda_line;
  logic [NPAIR-1:0] en_t, en_c, exp_en;
  logic [7:0] model [6];
  logic [7:0] wq [$];
  int checks = 0, failures = 0, mon_bad = 0;
  bit mon_on = 0, done = 0;

  assign sda_line = sda_h & ~sda_oe;
  always #5 clk = ~clk;

  clkctl_target dut (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pair_en_t_o(en_t), .pair_en_c_o(en_c)
  );

  // reference: expected enables from the R5 bit map applied to the model
  function automatic logic [NPAIR-1:0] calc_en();
    return {model[1][2], model[1][0], model[1][6], model[1][3], model[0][6], model[0][7]};
  endfunction

  // every-clock comparison of enables against the model (R10)
  always @(negedge clk)
    if (mon_on && (en_t !== exp_en || en_c !== exp_en)) mon_bad++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mon_check(input string tag);
    check(mon_bad == 0, tag, mon_bad, 0);
    mon_bad = 0;
  endtask

  task automatic gen_start();
    sda_h = 1; tick(Q); scl_h = 1; tick(Q); sda_h = 0; tick(Q); scl_h = 0; tick(Q);
  endtask

  task automatic gen_stop();
    sda_h = 0; tick(Q); scl_h = 1; tick(Q); sda_h = 1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; tick(Q); scl_h = 1; tick(2 * Q); scl_h = 0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, input int upd, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0 && upd >= 0) mon_on = 0;
      send_bit(d[i]);
    end
    sda_h = 1; tick(Q); scl_h = 1; tick(Q);
    acked = (sda_line == 1'b0);
    if (upd >= 0) begin
      if (upd < 5) model[upd] = d;
      exp_en = calc_en();
      mon_on = 1;
    end
    tick(Q); scl_h = 0; tick(Q);
  endtask

  task automatic read_byte(input bit host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1; tick(Q); scl_h = 1; tick(Q); d[i] = sda_line; tick(Q); scl_h = 0; tick(Q);
    end
    sda_h = ~host_ack; tick(Q); scl_h = 1; tick(2 * Q); scl_h = 0; tick(Q); sda_h = 1;
  endtask

  // block write of the bytes in wq after a dummy command and count
  task automatic do_write(input bit stop_after, input string tag);
    bit a;
    gen_start();
    write_byte(8'hD2, -1, a); check(a, {tag, " R1 write address ack"}, a, 1);
    write_byte(8'hA5, -1, a); check(a, {tag, " R2 command byte ack"}, a, 1);
    write_byte(8'h3C, -1, a); check(a, {tag, " R2 count byte ack"}, a, 1);
    for (int k = 0; k < wq.size(); k++) begin
      write_byte(wq[k], k, a);
      check(a, $sformatf("%s R2/R7 data ack %0d", tag, k), a, 1);
    end
    if (stop_after) gen_stop();
  endtask

  task automatic do_read(input int n, input bit stop_after, input string tag);
    bit a;
    logic [7:0] d, e;
    gen_start();
    write_byte(8'hD3, -1, a); check(a, {tag, " R1 read address ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, d);
      e = (k == 0) ? 8'd6 : model[k - 1];
      check(d === e, $sformatf("%s R4 read byte %0d", tag, k), d, e);
    end
    if (stop_after) gen_stop();
  endtask

  initial begin
    bit a;
    model[0] = 8'hC0; model[1] = 8'h4D; model[2] = 8'h00;
    model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h06;
    exp_en = calc_en();
    tick(5); rst = 0; tick(3);

    check(en_t === 6'h3F, "R6 true enables after reset", en_t, 6'h3F);
    check(en_c === 6'h3F, "R6 complement enables after reset", en_c, 6'h3F);
    check(sda_oe === 1'b0, "R6 sda released after reset", sda_oe, 0);
    mon_on = 1;
    do_read(7, 1, "R6 defaults");

    // partial write: two data bytes then stop
    wq.delete(); wq.push_back(8'h40); wq.push_back(8'h08);
    do_write(1, "R3 partial");
    tick(Q);
    check(en_t === 6'b000110, "R5 map after partial write", en_t, 6'b000110);
    check(sda_oe === 1'b0, "R11 released after stop", sda_oe, 0);
    do_read(7, 1, "R3 untouched registers");
    mon_check("R10 enables vs model");

    // foreign address is refused and the rest ignored
    gen_start();
    write_byte(8'hA0, -1, a); check(!a, "R1 foreign address not acked", a, 0);
    write_byte(8'h00, -1, a); check(!a, "R1 following byte ignored", a, 0);
    write_byte(8'h00, -1, a);
    gen_stop();
    tick(Q);
    check(en_t === 6'b000110, "R1 enables unchanged", en_t, 6'b000110);
    do_read(3, 1, "R1 registers unchanged");

    // long write running past the last writable register
    wq.delete();
    wq.push_back(8'h80); wq.push_back(8'h45); wq.push_back(8'h11); wq.push_back(8'h22);
    wq.push_back(8'h33); wq.push_back(8'h99); wq.push_back(8'h77); wq.push_back(8'h66);
    do_write(1, "R7 overrun");
    tick(Q);
    check(en_t === 6'b111001, "R5 map after full write", en_t, 6'b111001);
    do_read(7, 1, "R7 register 5 kept");

    // repeated start rewinds to register 0
    wq.delete(); wq.push_back(8'hC0);
    do_write(0, "R8 first part");
    wq.delete(); wq.push_back(8'h00);
    do_write(1, "R8 after repeated start");
    tick(Q);
    check(en_t === 6'b111000, "R8 second write hit register 0", en_t, 6'b111000);
    do_read(2, 0, "R8 read before repeated start");
    do_read(3, 1, "R8 read restarts at count");

    // all pairs off
    wq.delete(); wq.push_back(8'h00); wq.push_back(8'h00);
    do_write(1, "R9 all off");
    tick(Q);
    check(en_t === 6'h00, "R9 true enables low", en_t, 6'h00);
    check(en_c === 6'h00, "R9 complement enables low", en_c, 6'h00);

    // restore everything on
    wq.delete(); wq.push_back(8'hC0); wq.push_back(8'h4D);
    do_write(1, "R5 all on");
    tick(Q);
    check(en_t === 6'h3F && en_c === 6'h3F, "R5 all pairs on", en_t, 6'h3F);
    mon_check("R10 enables vs model");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule